// File: doc/BRIEF.md
# Segmented Ramp Waveform Store

This block holds the waveform tables of a ramp generator card. The tables form one flat byte-addressed space of ten tables, each 256 bytes long. Table n (counting from 1) occupies bytes 256·(n−1) through 256·n−1. The host can place a shared byte pointer anywhere in that space. It then streams 16-bit words into or out of the store through the same pointer. The pointer moves on by one word after each transfer, so a whole table, part of a table, or a run across several tables can be moved without reloading the pointer.

A separate register holds the number of the table that is currently being played back. A write that lands inside that table is refused and the memory is left as it was. The pointer still steps past the word, and a one-cycle rejection pulse reports the refused write.

Words going in use a valid/ready handshake. Reads are split into a command stream and a response stream. A read command is taken only when the single response slot is empty or is being emptied in the same cycle, so a response that is not consumed holds back the next command. The pointer-load and active-table controls are plain strobes without a handshake.

Top module: `ramp_store`

## Requirements
- R1: After reset, `ptr` is 0, `act_num` is 0, `rsp_valid` is 0 and `guard_hit` is 0.
- R2: A cycle with `ofs_load` high sets `ptr` on the next cycle to `ofs_value` with bit 0 cleared. A value of 2560 or more loads 0 instead.
- R3: A write handshake (`wr_valid` and `wr_ready` both high) stores `wr_data` at word address `ptr`/2 and advances `ptr` by 2.
- R4: A read-command handshake (`rd_valid` and `rd_ready` both high) presents the word at `ptr` on `rsp_data` with `rsp_valid` high in the next cycle, and advances `ptr` by 2.
- R5: A transfer made at `ptr` = 2558 takes `ptr` back to 0.
- R6: A cycle with `act_load` high sets `act_num` to `act_value` on the next cycle. Table n covers bytes 256·(n−1) to 256·n−1. An `act_num` of 0 marks no table as active.
- R7: A write handshake with `ptr` inside the table numbered `act_num` (nonzero) leaves the memory unchanged and still advances `ptr` by 2. It also raises `guard_hit` for exactly the next cycle. Any other write leaves `guard_hit` low.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` stays stable, `rd_ready` is low, and `ptr` does not move on reads.
- R9: While `ofs_load` is high, `wr_ready` and `rd_ready` are both low. While `wr_valid` is high, `rd_ready` is low, so only one transfer occurs per cycle.
- R10: A write in the same cycle as `act_load` is guarded using the `act_num` held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ofs_load | input | 1 | Load strobe for the byte pointer |
| ofs_value | input | 12 | Byte offset to load |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word can be taken |
| wr_data | input | 16 | Word to store |
| rd_valid | input | 1 | Read command offered |
| rd_ready | output | 1 | Read command can be taken |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Read response consumed |
| rsp_data | output | 16 | Word read out |
| act_load | input | 1 | Load strobe for the active table number |
| act_value | input | 4 | Active table number to load (0 = none) |
| act_num | output | 4 | Active table number |
| ptr | output | 12 | Current byte pointer |
| guard_hit | output | 1 | One-cycle pulse for a refused write |

## Verification
There are three ways two actions can meet in one cycle. A pointer load can coincide with an offered write, a write can coincide with a read command, and a change of the active table can coincide with a write into the table being activated. The bench drives each pair together in a single cycle. It then checks the ready outputs during that cycle. After the edge it checks where the pointer landed, whether `rsp_valid` rose, and whether `guard_hit` fired, based on the table number held before the load.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  parameter int NUM_RAMPS_D  = 10;
  parameter int RAMP_BYTES_D = 256;
  parameter int DATA_W_D     = 16;

  typedef enum logic [1:0] {
    XFER_NONE  = 2'd0,
    XFER_WRITE = 2'd1,
    XFER_READ  = 2'd2
  } xfer_e;
endpackage

// File: rtl/ramp_ptr.sv
module ramp_ptr #(
  parameter int AW          = 12,
  parameter int TOTAL_BYTES = 2560
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  localparam logic [AW:0] LIMIT = (AW+1)'(TOTAL_BYTES);

  logic [AW:0]   inc;
  logic [AW-1:0] ptr_d;

  always_comb begin
    inc   = {1'b0, ptr} + (AW+1)'(2);
    ptr_d = ptr;
    if (load) begin
      if ({1'b0, load_val} >= LIMIT) ptr_d = '0;
      else                           ptr_d = {load_val[AW-1:1], 1'b0};
    end else if (step) begin
      if (inc >= LIMIT) ptr_d = '0;
      else              ptr_d = inc[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end
endmodule

// File: rtl/ramp_guard.sv
module ramp_guard #(
  parameter int IW = 4,
  parameter int RW = 4
) (
  input  logic [IW-1:0] ramp_idx,
  input  logic [RW-1:0] act,
  output logic          hit
);
  logic [RW:0] idx_ext;

  always_comb begin
    idx_ext = (RW+1)'(ramp_idx) + (RW+1)'(1);
    hit     = (act != '0) && (idx_ext == {1'b0, act});
  end
endmodule

// File: rtl/ramp_mem.sv
module ramp_mem #(
  parameter int DW    = 16,
  parameter int WORDS = 1280,
  parameter int WAW   = 11
) (
  input  logic           clk,
  input  logic           we,
  input  logic           re,
  input  logic [WAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    if (re) rdata <= store[addr];
  end
endmodule

// File: rtl/ramp_store.sv
module ramp_store #(
  parameter int NUM_RAMPS  = ramp_pkg::NUM_RAMPS_D,
  parameter int RAMP_BYTES = ramp_pkg::RAMP_BYTES_D,
  parameter int DW         = ramp_pkg::DATA_W_D,
  localparam int TOTAL_BYTES = NUM_RAMPS * RAMP_BYTES,
  localparam int AW          = $clog2(TOTAL_BYTES),
  localparam int RW          = $clog2(NUM_RAMPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ofs_load,
  input  logic [AW-1:0] ofs_value,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic          act_load,
  input  logic [RW-1:0] act_value,
  output logic [RW-1:0] act_num,
  output logic [AW-1:0] ptr,
  output logic          guard_hit
);
  import ramp_pkg::*;

  localparam int WORDS = TOTAL_BYTES / 2;
  localparam int WAW   = AW - 1;
  localparam int RB_SH = $clog2(RAMP_BYTES);
  localparam int IW    = AW - RB_SH;

  xfer_e xfer;
  logic  hit;
  logic  mem_we;

  assign wr_ready = !ofs_load;
  assign rd_ready = !ofs_load && !wr_valid && (!rsp_valid || rsp_ready);

  always_comb begin
    if (wr_valid && wr_ready)      xfer = XFER_WRITE;
    else if (rd_valid && rd_ready) xfer = XFER_READ;
    else                           xfer = XFER_NONE;
  end

  assign mem_we = (xfer == XFER_WRITE) && !hit;

  ramp_ptr #(.AW(AW), .TOTAL_BYTES(TOTAL_BYTES)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ofs_load),
    .load_val (ofs_value),
    .step     (xfer != XFER_NONE),
    .ptr      (ptr)
  );

  ramp_guard #(.IW(IW), .RW(RW)) u_guard (
    .ramp_idx (ptr[AW-1:RB_SH]),
    .act      (act_num),
    .hit      (hit)
  );

  ramp_mem #(.DW(DW), .WORDS(WORDS), .WAW(WAW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .re    (xfer == XFER_READ),
    .addr  (ptr[AW-1:1]),
    .wdata (wr_data),
    .rdata (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_num   <= '0;
      rsp_valid <= 1'b0;
      guard_hit <= 1'b0;
    end else begin
      if (act_load) act_num <= act_value;
      guard_hit <= (xfer == XFER_WRITE) && hit;
      if (xfer == XFER_READ) rsp_valid <= 1'b1;
      else if (rsp_ready)    rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ramp_store_chk.sv
module ramp_store_chk #(
  parameter int AW          = 12,
  parameter int DW          = 16,
  parameter int RW          = 4,
  parameter int TOTAL_BYTES = 2560
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ofs_load,
  input logic [AW-1:0] ofs_value,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          act_load,
  input logic [RW-1:0] act_value,
  input logic [RW-1:0] act_num,
  input logic [AW-1:0] ptr,
  input logic          guard_hit
);
  localparam logic [AW:0] LIMIT = (AW+1)'(TOTAL_BYTES);

  // R2
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ptr} < LIMIT) && (ptr[0] == 1'b0));

  // R3
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=>
      (({1'b0, $past(ptr)} + 2 >= LIMIT) ? (ptr == '0) : (ptr == $past(ptr) + AW'(2))));

  // R4
  rd_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  // R6
  act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_load |=> (act_num == $past(act_value)));

  // R7
  guard_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guard_hit |-> $past(wr_valid && wr_ready));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready);

  // R9
  load_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_load |-> (!wr_ready && !rd_ready));

  // R9
  one_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_ready);

  // R2
  load_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_load |=> (({1'b0, $past(ofs_value)} >= LIMIT) ? (ptr == '0)
                  : (ptr == {$past(ofs_value[AW-1:1]), 1'b0})));
endmodule

bind ramp_store ramp_store_chk #(
  .AW(AW), .DW(DW), .RW(RW), .TOTAL_BYTES(TOTAL_BYTES)
) u_chk (.*);

// File: tb/sim_ramp_store.sv
module sim_ramp_store;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ofs_load;
  logic [11:0] ofs_value;
  logic        wr_valid;
  logic        wr_ready;
  logic [15:0] wr_data;
  logic        rd_valid;
  logic        rd_ready;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [15:0] rsp_data;
  logic        act_load;
  logic [3:0]  act_value;
  logic [3:0]  act_num;
  logic [11:0] ptr;
  logic        guard_hit;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ramp_store u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_ptr(input int v);
    ofs_load = 1'b1; ofs_value = 12'(v);
    tick();
    ofs_load = 1'b0;
  endtask

  task automatic put(input int d);
    wr_valid = 1'b1; wr_data = 16'(d);
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic get(output int d);
    rd_valid = 1'b1;
    tick();
    rd_valid = 1'b0;
    d = int'(rsp_data);
    if (rsp_valid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R4: rsp_valid got 0 expected 1");
    end
  endtask

  task automatic set_act(input int n);
    act_load = 1'b1; act_value = 4'(n);
    tick();
    act_load = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ptr", int'(ptr), 0);
    chk("R1 act_num", int'(act_num), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 guard_hit", int'(guard_hit), 0);
  endtask

  task automatic t_offset();
    load_ptr(513);
    chk("R2 odd offset", int'(ptr), 512);
    load_ptr(3000);
    chk("R2 beyond end", int'(ptr), 0);
    load_ptr(2560);
    chk("R2 at end", int'(ptr), 0);
  endtask

  task automatic t_stream();
    int d;
    load_ptr(512);
    for (int i = 0; i < 4; i++) put(16'hA000 + i);
    chk("R3 ptr after 4 writes", int'(ptr), 520);
    load_ptr(0);
    put(16'h1111); put(16'h2222);
    chk("R3 partial slice ptr", int'(ptr), 4);
    load_ptr(512);
    for (int i = 0; i < 4; i++) begin
      get(d);
      chk("R4 read data", d, 16'hA000 + i);
    end
    chk("R4 ptr after reads", int'(ptr), 520);
    tick();
    chk("R4 rsp drains", int'(rsp_valid), 0);
    load_ptr(0);
    get(d); chk("R4 slice word0", d, 16'h1111);
    get(d); chk("R4 slice word1", d, 16'h2222);
    tick();
  endtask

  task automatic t_wrap();
    int d;
    load_ptr(2558);
    put(16'h7E7E);
    chk("R5 wrap on write", int'(ptr), 0);
    load_ptr(2558);
    get(d);
    chk("R5 wrap on read", int'(ptr), 0);
    chk("R5 last word", d, 16'h7E7E);
    tick();
  endtask

  task automatic t_guard();
    int d;
    load_ptr(766); put(16'h0766);
    load_ptr(510); put(16'h0510);
    set_act(3);
    chk("R6 act_num", int'(act_num), 3);
    load_ptr(512);
    put(16'hDEAD);
    chk("R7 guard_hit pulse", int'(guard_hit), 1);
    chk("R7 ptr advances", int'(ptr), 514);
    tick();
    chk("R7 pulse one cycle", int'(guard_hit), 0);
    load_ptr(766);
    put(16'hBEEF);
    chk("R7 last byte of table", int'(guard_hit), 1);
    load_ptr(510);
    put(16'h5A5A);
    chk("R7 neighbour table allowed", int'(guard_hit), 0);
    load_ptr(768);
    put(16'h0768);
    chk("R7 next table allowed", int'(guard_hit), 0);
    set_act(0);
    load_ptr(512);
    get(d); chk("R7 memory unchanged", d, 16'hA000);
    load_ptr(766);
    get(d); chk("R7 memory unchanged end", d, 16'h0766);
    load_ptr(510);
    get(d); chk("R7 allowed write stored", d, 16'h5A5A);
    tick();
  endtask

  task automatic t_backpressure();
    int d;
    load_ptr(512);
    rsp_ready = 1'b0;
    rd_valid = 1'b1;
    tick();
    d = int'(rsp_data);
    chk("R8 first data", d, 16'hA000);
    chk("R8 rd_ready held low", int'(rd_ready), 0);
    tick();
    chk("R8 rsp_valid held", int'(rsp_valid), 1);
    chk("R8 data stable", int'(rsp_data), 16'hA000);
    chk("R8 ptr frozen", int'(ptr), 514);
    rsp_ready = 1'b1;
    #0;
    chk("R8 rd_ready when consumed", int'(rd_ready), 1);
    tick();
    rd_valid = 1'b0;
    chk("R8 next data", int'(rsp_data), 16'hA001);
    tick();
  endtask

  task automatic t_collide();
    int d;
    load_ptr(1000);
    ofs_load = 1'b1; ofs_value = 12'd1024;
    wr_valid = 1'b1; wr_data = 16'hCAFE;
    rd_valid = 1'b1;
    #1;
    chk("R9 wr_ready low on load", int'(wr_ready), 0);
    chk("R9 rd_ready low on load", int'(rd_ready), 0);
    tick();
    ofs_load = 1'b0; rd_valid = 1'b0;
    chk("R9 load wins", int'(ptr), 1024);
    wr_valid = 1'b1; rd_valid = 1'b1; wr_data = 16'h1234;
    #1;
    chk("R9 read blocked by write", int'(rd_ready), 0);
    tick();
    wr_valid = 1'b0; rd_valid = 1'b0;
    chk("R9 one step only", int'(ptr), 1026);
    chk("R9 no response", int'(rsp_valid), 0);
    load_ptr(1024);
    get(d); chk("R9 write landed", d, 16'h1234);
    tick();
  endtask

  task automatic t_act_same();
    load_ptr(1024);
    act_load = 1'b1; act_value = 4'd5;
    wr_valid = 1'b1; wr_data = 16'h5555;
    tick();
    act_load = 1'b0; wr_valid = 1'b0;
    chk("R10 old act used", int'(guard_hit), 0);
    chk("R10 act_num updated", int'(act_num), 5);
    put(16'h6666);
    chk("R10 new act guards", int'(guard_hit), 1);
    set_act(0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ofs_load = 1'b0; ofs_value = '0;
    wr_valid = 1'b0; wr_data = '0;
    rd_valid = 1'b0; rsp_ready = 1'b1;
    act_load = 1'b0; act_value = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_offset();
    t_stream();
    t_wrap();
    t_guard();
    t_backpressure();
    t_collide();
    t_act_same();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule